// File: doc/BRIEF.md
# GPIO Bank Output Drive Controller

This block turns the output-side configuration of a 40-pin general-purpose I/O expander into per-pin pad controls. The pins are grouped as five banks of eight. For every pin it produces a drive level and a drive enable. These are formed from the stored output value, the pin's direction bit, its output structure (open-drain or totem-pole), a bank-level force override and an external output-enable pin whose active level is programmable.

Output-register bytes arrive from a serial bus engine as byte-write strobes, followed by an acknowledge strobe. A stop strobe marks the end of a bus transaction. Every byte first lands in a one-byte-per-bank staging buffer. A mode bit decides when staged bytes move to the output registers. With the bit set, each byte moves at its own acknowledge. With the bit clear, all staged banks move together at the stop, so all banks change on the same clock edge. The direction, structure, force and mode registers live in the surrounding register file and reach the block as plain inputs.

Top module: `gpio_bank_drive`

## Requirements
- R1: After reset, the output-register read-back `outRegRd` is all zeros. With every direction bit at 1 (its reset value), `padOe` is all zeros.
- R2: A pin whose direction bit is 1 is an input and never has `padOe` set. A pin whose direction bit is 0 is an output.
- R3: With mode bit 1 at 1, a written byte is not yet visible on `outRegRd` after the write strobe. It appears in its bank slice in the cycle after the acknowledge strobe.
- R4: With mode bit 1 at 0, acknowledges leave `outRegRd` unchanged. At the stop strobe, every bank staged since the last commit is applied on the same edge.
- R5: Writing the same bank twice before a commit keeps only the later byte.
- R6: A write strobe whose bank index is 5, 6 or 7 changes no output register and no pin.
- R7: The force register holds bank bits in bits 0 to 4 and a select bit in bit 7. With the select bit at 0, a bank whose bit is 0 drives all its pins at level 0, and a bank whose bit is 1 drives its output-register value.
- R8: With the select bit at 1, a bank whose bit is 1 drives all its pins at level 1, and a bank whose bit is 0 drives its output-register value. Bits 5 and 6 of the force register have no effect.
- R9: The force register never changes `outRegRd`.
- R10: Structure bits 0 to 3 select bank 0 pins in pairs: bit k covers pins 2k and 2k+1. Structure bits 4 to 7 each cover one whole bank, banks 1 to 4. A bit of 1 means totem-pole: `padOut` equals the level and `padOe` is set. A bit of 0 means open-drain: `padOut` is 0, and `padOe` is set only when the level is 0.
- R11: Mode bit 0 sets the active level of `oePin`: 0 means active low, 1 means active high. While `oePin` is inactive, `padOe` is all zeros.
- R12: A reset while bytes are staged discards them, so a later stop strobe commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Byte-write strobe for an output register |
| wrBank | input | 3 | Bank index of the written byte |
| wrData | input | 8 | Written byte |
| ackStrobe | input | 1 | Acknowledge of the written byte |
| stopStrobe | input | 1 | Bus stop condition |
| dirCfg | input | 40 | Direction bits, 1 = input |
| structCfg | input | 8 | Output structure selection, 1 = totem-pole |
| allBankCfg | input | 8 | Force register: bank bits [4:0], select bit [7] |
| modeCfg | input | 8 | Mode: bit 0 OE polarity, bit 1 commit on acknowledge |
| oePin | input | 1 | External output-enable pin |
| padOut | output | 40 | Per-pin drive level |
| padOe | output | 40 | Per-pin drive enable |
| outRegRd | output | 40 | Output-register contents for read-back |

## Verification
The hardest state to reach from the ports is a staging buffer holding several banks at once, one of them rewritten, while the output registers still hold older values. The stimulus reaches it by clearing the acknowledge-commit mode bit and then interleaving writes and acknowledges across banks before any stop. It checks that nothing moved, then that everything moved on the single stop edge. A reset is also placed between staging and stop, which shows that the staged bytes are lost. The pad mapping is swept over every force-register value, against several structure patterns, both OE levels and both polarities. The expected pin values are computed from the bank and pair arithmetic.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
  localparam int NUM_BANKS      = 5;
  localparam int BANK_W         = 8;
  localparam int PIN_N          = NUM_BANKS * BANK_W;
  localparam int IDX_W          = $clog2(NUM_BANKS);
  localparam int STRUCT_W       = BANK_W / 2 + NUM_BANKS - 1;
  localparam int ALL_W          = 8;
  localparam int ALL_SEL_BIT    = ALL_W - 1;
  localparam int MODE_W         = 8;
  localparam int MODE_OEPOL_BIT = 0;
  localparam int MODE_OCH_BIT   = 1;

  typedef struct packed {
    logic              stageWe;
    logic [IDX_W-1:0]  stageBank;
    logic [BANK_W-1:0] stageData;
    logic              commitAll;
  } gpdStrobe_t;
endpackage

// File: rtl/gpd_ctrl.sv
module gpd_ctrl
  import gpd_pkg::*;
(
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrBank,
  input  logic [BANK_W-1:0] wrData,
  input  logic              ackStrobe,
  input  logic              stopStrobe,
  input  logic              ackCommitMode,
  output gpdStrobe_t        strobes
);
  localparam logic [IDX_W:0] BANK_LIMIT = (IDX_W+1)'(NUM_BANKS);

  logic bankInRange;
  assign bankInRange = ({1'b0, wrBank} < BANK_LIMIT);

  always_comb begin
    strobes.stageWe   = wrValid && bankInRange;
    strobes.stageBank = wrBank;
    strobes.stageData = wrData;
    // A stop flushes whatever is staged; an acknowledge does so only in
    // per-byte commit mode.
    strobes.commitAll = stopStrobe || (ackStrobe && ackCommitMode);
  end
endmodule

// File: rtl/gpd_datapath.sv
module gpd_datapath
  import gpd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  gpdStrobe_t       strobes,
  output logic [PIN_N-1:0] outRegFlat
);
  logic [NUM_BANKS-1:0] pending;
  logic [PIN_N-1:0]     stageFlat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic hitBank;
    assign hitBank = strobes.stageWe && (strobes.stageBank == IDX_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageFlat[b*BANK_W +: BANK_W]  <= '0;
        outRegFlat[b*BANK_W +: BANK_W] <= '0;
        pending[b]                     <= 1'b0;
      end else begin
        if (strobes.commitAll && pending[b])
          outRegFlat[b*BANK_W +: BANK_W] <= stageFlat[b*BANK_W +: BANK_W];
        if (hitBank) begin
          stageFlat[b*BANK_W +: BANK_W] <= strobes.stageData;
          pending[b]                    <= 1'b1;
        end else if (strobes.commitAll) begin
          pending[b] <= 1'b0;
        end
      end
    end

    AST_COMMIT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.commitAll && pending[b]) |=>
        (outRegFlat[b*BANK_W +: BANK_W] == $past(stageFlat[b*BANK_W +: BANK_W]))); // R4
  end

  AST_OUTREG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.commitAll) |=> $stable(outRegFlat)); // R3

  AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitAll && !strobes.stageWe) |=> (pending == '0)); // R4
endmodule

// File: rtl/gpd_padmux.sv
module gpd_padmux
  import gpd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PIN_N-1:0]    outRegFlat,
  input  logic [PIN_N-1:0]    dirCfg,
  input  logic [STRUCT_W-1:0] structCfg,
  input  logic [ALL_W-1:0]    allBankCfg,
  input  logic                oePolarity,
  input  logic                oePin,
  output logic [PIN_N-1:0]    padOut,
  output logic [PIN_N-1:0]    padOe
);
  logic oeEnable;
  logic forceSel;
  logic allBankUnused;

  assign oeEnable      = (oePin == oePolarity);
  assign forceSel      = allBankCfg[ALL_SEL_BIT];
  assign allBankUnused = ^allBankCfg[ALL_SEL_BIT-1:NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic forceOn;
    // Bank bit equal to select bit: the bank is forced to the select level.
    assign forceOn = (allBankCfg[b] == forceSel);

    for (genvar p = 0; p < BANK_W; p++) begin : gPin
      localparam int PIN  = b * BANK_W + p;
      localparam int SIDX = (b == 0) ? (p / 2) : (BANK_W / 2 + b - 1);
      logic level;
      logic totem;
      assign level       = forceOn ? forceSel : outRegFlat[PIN];
      assign totem       = structCfg[SIDX];
      assign padOut[PIN] = totem & level;
      assign padOe[PIN]  = ~dirCfg[PIN] & oeEnable & (totem | ~level);
    end
  end

  AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & dirCfg) == '0)); // R2

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (oePin != oePolarity) |-> (padOe == '0)); // R11

  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe[0] && !structCfg[0]) |-> !padOut[0])); // R10
endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive
  import gpd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrValid,
  input  logic [IDX_W-1:0]    wrBank,
  input  logic [BANK_W-1:0]   wrData,
  input  logic                ackStrobe,
  input  logic                stopStrobe,
  input  logic [PIN_N-1:0]    dirCfg,
  input  logic [STRUCT_W-1:0] structCfg,
  input  logic [ALL_W-1:0]    allBankCfg,
  input  logic [MODE_W-1:0]   modeCfg,
  input  logic                oePin,
  output logic [PIN_N-1:0]    padOut,
  output logic [PIN_N-1:0]    padOe,
  output logic [PIN_N-1:0]    outRegRd
);
  gpdStrobe_t       strobes;
  logic [PIN_N-1:0] outRegFlat;
  logic             modeUnused;

  assign modeUnused = ^modeCfg[MODE_W-1:MODE_OCH_BIT+1];

  gpd_ctrl uCtrl (
    .wrValid       (wrValid),
    .wrBank        (wrBank),
    .wrData        (wrData),
    .ackStrobe     (ackStrobe),
    .stopStrobe    (stopStrobe),
    .ackCommitMode (modeCfg[MODE_OCH_BIT]),
    .strobes       (strobes)
  );

  gpd_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .outRegFlat (outRegFlat)
  );

  gpd_padmux uPad (
    .clk        (clk),
    .rstN       (rstN),
    .outRegFlat (outRegFlat),
    .dirCfg     (dirCfg),
    .structCfg  (structCfg),
    .allBankCfg (allBankCfg),
    .oePolarity (modeCfg[MODE_OEPOL_BIT]),
    .oePin      (oePin),
    .padOut     (padOut),
    .padOe      (padOe)
  );

  assign outRegRd = outRegFlat;
endmodule

// File: tb/tb_gpio_bank_drive.sv
module tb_gpio_bank_drive;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [2:0]  wrBank = '0;
  logic [7:0]  wrData = '0;
  logic        ackStrobe = 1'b0;
  logic        stopStrobe = 1'b0;
  logic [39:0] dirCfg = '1;
  logic [7:0]  structCfg = 8'hFF;
  logic [7:0]  allBankCfg = 8'h1F;
  logic [7:0]  modeCfg = 8'h00;
  logic        oePin = 1'b0;
  wire  [39:0] padOut;
  wire  [39:0] padOe;
  wire  [39:0] outRegRd;

  int errors = 0;
  int checks = 0;

  logic [39:0] expReg = '0;
  logic [39:0] expStage = '0;
  logic [4:0]  expPend = '0;

  always #10 clk = ~clk;

  gpio_bank_drive dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrBank(wrBank), .wrData(wrData),
    .ackStrobe(ackStrobe), .stopStrobe(stopStrobe), .dirCfg(dirCfg),
    .structCfg(structCfg), .allBankCfg(allBankCfg), .modeCfg(modeCfg),
    .oePin(oePin), .padOut(padOut), .padOe(padOe), .outRegRd(outRegRd)
  );

  task automatic checkVec(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelCommit();
    for (int b = 0; b < 5; b++)
      if (expPend[b]) begin
        expReg[b*8 +: 8] = expStage[b*8 +: 8];
        expPend[b] = 1'b0;
      end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expReg = '0; expStage = '0; expPend = '0;
  endtask

  task automatic doWrite(input logic [2:0] bank, input logic [7:0] data);
    wrBank = bank; wrData = data; wrValid = 1'b1;
    @(posedge clk); @(negedge clk);
    wrValid = 1'b0;
    if (bank < 3'd5) begin
      expStage[bank*8 +: 8] = data;
      expPend[bank] = 1'b1;
    end
  endtask

  task automatic doAck();
    ackStrobe = 1'b1;
    @(posedge clk); @(negedge clk);
    ackStrobe = 1'b0;
    if (modeCfg[1]) modelCommit();
  endtask

  task automatic doStop();
    stopStrobe = 1'b1;
    @(posedge clk); @(negedge clk);
    stopStrobe = 1'b0;
    modelCommit();
  endtask

  // Expected pins from the requirement arithmetic (R2 R7 R8 R10 R11).
  task automatic expPads(output logic [39:0] eOut, output logic [39:0] eOe);
    for (int b = 0; b < 5; b++)
      for (int p = 0; p < 8; p++) begin
        int  pin  = b * 8 + p;
        int  sidx = (b == 0) ? p / 2 : 3 + b;
        logic sel  = allBankCfg[7];
        logic lvl  = (allBankCfg[b] == sel) ? sel : expReg[pin];
        logic tot  = structCfg[sidx];
        logic en   = !dirCfg[pin] && (oePin == modeCfg[0]);
        eOut[pin] = tot & lvl;
        eOe[pin]  = en & (tot | ~lvl);
      end
  endtask

  task automatic checkPads(input string tag);
    logic [39:0] eOut, eOe;
    #1;
    expPads(eOut, eOe);
    checkVec({tag, " padOut"}, padOut, eOut);
    checkVec({tag, " padOe"}, padOe, eOe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] structSet [6] = '{8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h0F, 8'hF0};
    logic [39:0] dirSet [2] = '{40'h0, 40'hF0_0F_33_CC_0F};

    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    checkVec("R1 outRegRd after reset", outRegRd, 40'h0);
    checkVec("R1 padOe during reset", padOe, 40'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    checkVec("R1 padOe after reset", padOe, 40'h0);

    // R3: commit on acknowledge
    dirCfg = '0; structCfg = 8'hFF; allBankCfg = 8'h1F; modeCfg = 8'h02; oePin = 1'b0;
    for (int b = 0; b < 5; b++) begin
      logic [7:0] v = 8'h5A ^ 8'(b * 37);
      doWrite(3'(b), v);
      #1 checkVec("R3 no change before ack", outRegRd, expReg);
      doAck();
      #1 checkVec("R3 applied at ack", outRegRd, expReg);
      checkPads("R2 R3 totem outputs");
    end

    // R4 R5: stage and commit at stop
    modeCfg = 8'h00;
    doWrite(3'd0, 8'h3C); doAck();
    doWrite(3'd3, 8'h81); doAck();
    doWrite(3'd3, 8'h7E); doAck();
    doWrite(3'd4, 8'hC3); doAck();
    #1 checkVec("R4 staged bytes held back at ack", outRegRd, expReg);
    doStop();
    #1 checkVec("R4 staged banks applied at stop", outRegRd, expReg);
    checkVec("R5 second write to bank 3 wins", {32'h0, outRegRd[31:24]}, 40'h7E);

    // R6: out-of-range bank index ignored
    for (int i = 5; i < 8; i++) begin
      doWrite(3'(i), 8'hFF); doAck(); doStop();
      #1 checkVec("R6 out-of-range bank ignored", outRegRd, expReg);
      checkPads("R6 pins unchanged");
    end
    modeCfg = 8'h02;
    doWrite(3'd7, 8'h00); doAck();
    #1 checkVec("R6 ignored in ack mode", outRegRd, expReg);

    // R2 R7 R8 R9 R10 R11: sweep of force, structure, direction, OE
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 6; s++)
        for (int a = 0; a < 256; a++) begin
          dirCfg = dirSet[d]; structCfg = structSet[s]; allBankCfg = 8'(a);
          #1 checkVec("R9 force does not touch outRegRd", outRegRd, expReg);
          for (int pol = 0; pol < 2; pol++)
            for (int oe = 0; oe < 2; oe++) begin
              modeCfg = {6'b0, 1'b1, 1'(pol)};
              oePin = 1'(oe);
              checkPads("R2 R7 R8 R10 R11 pin map");
            end
        end

    // R12: reset drops staged bytes
    allBankCfg = 8'h1F; dirCfg = '0; structCfg = 8'hFF; modeCfg = 8'h00; oePin = 1'b0;
    doWrite(3'd2, 8'hFF); doAck();
    doWrite(3'd1, 8'h99); doAck();
    doReset();
    doStop();
    #1 checkVec("R12 reset discards staged bytes", outRegRd, 40'h0);
    checkPads("R12 pins after discarded commit");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule